// File: doc/BRIEF.md
# E1 Receive Alarm Detector

This block watches the receive side of a framed E1 line and keeps six alarm flags up to date. The framer in front of it has already found alignment. It delivers each received bit with a valid strobe, plus position strobes that mark the bits this block cares about:

- bit 3 of a non-alignment frame
- bit 6 of timeslot 16 in frame 0
- each Sa7 bit
- the last bit of every two-frame (512-bit) window

Each alarm has its own asymmetric rule for setting and for clearing. These rules are built from:

- runs of zeros
- the density of ones in a fixed 255-bit window
- filters that require several consecutive matching samples
- a two-out-of-three vote

A loss-of-sync flag follows the framer's sync status and the manual resync request.

All counters saturate. Every alarm is held in a register, so each output reflects the inputs of the previous clock edge. A strobe only counts in a cycle where the bit-valid strobe is also high, and the marked bit is the `rx_bit` of that cycle. The window marker is the exception: it acts in any cycle.

Top module: `e1_rx_alarm_mon`

## Requirements
- R1: `los_o` is 1 after reset. It goes to 0 on the clock edge after `frame_sync` goes from 0 to 1, unless `resync_req` is high in that cycle.
- R2: `los_o` goes to 1 on the edge after `frame_sync` goes from 1 to 0, or after any cycle with `resync_req` high. It then stays 1 until the next rise of `frame_sync`.
- R3: `carrier_loss_o` sets when the number of consecutive valid zero bits reaches a threshold. The threshold is 255 when `cl_long_sel`=0 and 2048 when `cl_long_sel`=1. Cycles with `bit_vld`=0 neither count toward nor break the run. A valid one resets the run.
- R4: Valid bits are grouped into back-to-back windows of 255 bits, the first window starting at the first valid bit after reset. `carrier_loss_o` clears on the edge of the last bit of a window that held at least 32 ones. A window with 31 ones leaves it set.
- R5: `remote_alarm_o` sets after three consecutive non-align bit-3 samples equal to 1. It clears after three consecutive samples equal to 0. A sample that matches the current state restarts the count.
- R6: At each `win_end` pulse, `all_ones_o` becomes 1 if fewer than three valid zeros arrived since the previous pulse (or since reset), and 0 otherwise. The count includes the bit of the pulse cycle. The count then restarts.
- R7: `dist_mf_alarm_o` sets after two consecutive timeslot-16 bit-6 samples equal to 1 and clears after two consecutive samples equal to 0.
- R8: `link_alarm_o` is 1 when at least two of the last three Sa7 samples were 0. The history holds ones after reset.
- R9: A position strobe with `bit_vld`=0 has no effect on `remote_alarm_o`, `dist_mf_alarm_o` or `link_alarm_o`.
- R10: After reset every alarm output except `los_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Received bit is valid this cycle |
| rx_bit | input | 1 | Received bit |
| nfas_b3_stb | input | 1 | Marks bit 3 of a non-alignment frame |
| ts16_b6_stb | input | 1 | Marks bit 6 of timeslot 16 in frame 0 |
| sa7_stb | input | 1 | Marks an Sa7 bit |
| win_end | input | 1 | Last bit of a two-frame window |
| frame_sync | input | 1 | Framer is in frame alignment |
| resync_req | input | 1 | Manual resync request pulse |
| cl_long_sel | input | 1 | 0: carrier loss after 255 zeros, 1: after 2048 |
| los_o | output | 1 | Loss of frame synchronisation |
| carrier_loss_o | output | 1 | Receive carrier loss |
| remote_alarm_o | output | 1 | Remote alarm from the far end |
| all_ones_o | output | 1 | Unframed all-ones received |
| dist_mf_alarm_o | output | 1 | Distant multiframe alarm |
| link_alarm_o | output | 1 | Link-status alarm from the Sa7 vote |

## Verification
The checker checks on every cycle the causal rules that can be seen at the ports:
- loss-of-sync follows the edges of `frame_sync` and the resync pulse.
- carrier loss can only set on a valid zero and only clear on a valid bit.
- each filtered alarm moves only in a cycle where its qualified strobe, or the window marker, occurs.

Only the bench's scenarios can show the exact counts. These are the threshold at 254 against 255 zeros and 2047 against 2048 zeros, the 31-against-32 ones density at a window boundary, the three- and two-sample persistence with broken runs, the 2-against-3 zero count per window, and the sliding Sa7 vote.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

    localparam int CL_SHORT_RUN  = 255;
    localparam int CL_LONG_RUN   = 2048;
    localparam int DENS_WIN_LEN  = 255;
    localparam int DENS_MIN_ONES = 32;
    localparam int RA_PERSIST    = 3;
    localparam int DMA_PERSIST   = 2;
    localparam int AO_MAX_ZEROS  = 2;

    typedef struct packed {
        logic los;
        logic cl;
        logic ra;
        logic ao;
        logic dma;
        logic link;
    } alarm_vec_t;

    function automatic logic vote_zeros(input logic [2:0] hist);
        int unsigned zeros;
        zeros = 0;
        for (int i = 0; i < 3; i++) begin
            if (!hist[i]) zeros++;
        end
        return (zeros >= 2);
    endfunction

endpackage

// File: rtl/e1_persist_filter.sv
module e1_persist_filter #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    input  logic smp_bit,
    output logic state_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] run_q;
    logic          state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            run_q   <= '0;
        end else if (smp_vld) begin
            if (smp_bit != state_q) begin
                if (run_q == LAST) begin
                    state_q <= smp_bit;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/e1_carrier_det.sv
module e1_carrier_det #(
    parameter int SHORT_RUN = 255,
    parameter int LONG_RUN  = 2048,
    parameter int WIN_LEN   = 255,
    parameter int MIN_ONES  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic rx_bit,
    input  logic long_sel,
    output logic loss_o
);
    localparam int RW = $clog2(LONG_RUN + 1);
    localparam int PW = $clog2(WIN_LEN);
    localparam int OW = $clog2(MIN_ONES + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(LONG_RUN);
    localparam logic [RW-1:0] THR_S   = RW'(SHORT_RUN);
    localparam logic [PW-1:0] POS_END = PW'(WIN_LEN - 1);
    localparam logic [OW-1:0] ONES_OK = OW'(MIN_ONES);

    logic [RW-1:0] run_q, run_nx, thr;
    logic [PW-1:0] pos_q;
    logic [OW-1:0] ones_q, ones_nx;
    logic          loss_q, set_hit, win_last, dense;

    always_comb begin
        thr     = long_sel ? RUN_MAX : THR_S;
        run_nx  = rx_bit ? '0 : ((run_q == RUN_MAX) ? run_q : run_q + 1'b1);
        set_hit = bit_vld && !rx_bit && (run_nx >= thr);
        ones_nx = (rx_bit && ones_q < ONES_OK) ? ones_q + 1'b1 : ones_q;
        win_last = (pos_q == POS_END);
        dense    = (ones_nx >= ONES_OK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            pos_q  <= '0;
            ones_q <= '0;
            loss_q <= 1'b0;
        end else if (bit_vld) begin
            run_q <= run_nx;
            if (win_last) begin
                pos_q  <= '0;
                ones_q <= '0;
            end else begin
                pos_q  <= pos_q + 1'b1;
                ones_q <= ones_nx;
            end
            if (set_hit) begin
                loss_q <= 1'b1;
            end else if (win_last && dense) begin
                loss_q <= 1'b0;
            end
        end
    end

    assign loss_o = loss_q;
endmodule

// File: rtl/e1_allones_det.sv
module e1_allones_det #(
    parameter int MAX_ZEROS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic rx_bit,
    input  logic win_end,
    output logic all_ones_o
);
    localparam int ZW = $clog2(MAX_ZEROS + 2);
    localparam logic [ZW-1:0] ZCAP = ZW'(MAX_ZEROS + 1);
    localparam logic [ZW-1:0] ZLIM = ZW'(MAX_ZEROS);

    logic [ZW-1:0] zeros_q, zeros_nx;
    logic          ao_q;

    always_comb begin
        zeros_nx = zeros_q;
        if (bit_vld && !rx_bit && zeros_q < ZCAP) zeros_nx = zeros_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zeros_q <= '0;
            ao_q    <= 1'b0;
        end else if (win_end) begin
            ao_q    <= (zeros_nx <= ZLIM);
            zeros_q <= '0;
        end else begin
            zeros_q <= zeros_nx;
        end
    end

    assign all_ones_o = ao_q;
endmodule

// File: rtl/e1_rx_alarm_mon.sv
module e1_rx_alarm_mon
    import e1_alarm_pkg::*;
#(
    parameter int SHORT_RUN = CL_SHORT_RUN,
    parameter int LONG_RUN  = CL_LONG_RUN,
    parameter int WIN_LEN   = DENS_WIN_LEN,
    parameter int MIN_ONES  = DENS_MIN_ONES,
    parameter int RA_DEPTH  = RA_PERSIST,
    parameter int DMA_DEPTH = DMA_PERSIST,
    parameter int AO_ZEROS  = AO_MAX_ZEROS
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic rx_bit,
    input  logic nfas_b3_stb,
    input  logic ts16_b6_stb,
    input  logic sa7_stb,
    input  logic win_end,
    input  logic frame_sync,
    input  logic resync_req,
    input  logic cl_long_sel,
    output logic los_o,
    output logic carrier_loss_o,
    output logic remote_alarm_o,
    output logic all_ones_o,
    output logic dist_mf_alarm_o,
    output logic link_alarm_o
);
    alarm_vec_t al;
    logic       fsync_q;
    logic       los_q;
    logic [2:0] sa7_hist_q, sa7_hist_nx;
    logic       link_q;
    logic       sa7_take;

    // loss-of-sync: edge tracking of the framer's sync flag
    always_ff @(posedge clk) begin
        fsync_q <= frame_sync;
        if (rst) begin
            los_q <= 1'b1;
        end else if (resync_req || (fsync_q && !frame_sync)) begin
            los_q <= 1'b1;
        end else if (!fsync_q && frame_sync) begin
            los_q <= 1'b0;
        end
    end

    // Sa7 two-of-three vote
    assign sa7_take    = bit_vld && sa7_stb;
    assign sa7_hist_nx = {sa7_hist_q[1:0], rx_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            sa7_hist_q <= 3'b111;
            link_q     <= 1'b0;
        end else if (sa7_take) begin
            sa7_hist_q <= sa7_hist_nx;
            link_q     <= vote_zeros(sa7_hist_nx);
        end
    end

    e1_carrier_det #(
        .SHORT_RUN (SHORT_RUN),
        .LONG_RUN  (LONG_RUN),
        .WIN_LEN   (WIN_LEN),
        .MIN_ONES  (MIN_ONES)
    ) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .rx_bit   (rx_bit),
        .long_sel (cl_long_sel),
        .loss_o   (al.cl)
    );

    e1_persist_filter #(.DEPTH(RA_DEPTH)) u_ra_filt (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (bit_vld && nfas_b3_stb),
        .smp_bit (rx_bit),
        .state_o (al.ra)
    );

    e1_persist_filter #(.DEPTH(DMA_DEPTH)) u_dma_filt (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (bit_vld && ts16_b6_stb),
        .smp_bit (rx_bit),
        .state_o (al.dma)
    );

    e1_allones_det #(.MAX_ZEROS(AO_ZEROS)) u_allones (
        .clk        (clk),
        .rst        (rst),
        .bit_vld    (bit_vld),
        .rx_bit     (rx_bit),
        .win_end    (win_end),
        .all_ones_o (al.ao)
    );

    assign al.los  = los_q;
    assign al.link = link_q;

    assign los_o           = al.los;
    assign carrier_loss_o  = al.cl;
    assign remote_alarm_o  = al.ra;
    assign all_ones_o      = al.ao;
    assign dist_mf_alarm_o = al.dma;
    assign link_alarm_o    = al.link;
endmodule

// File: rtl/e1_rx_alarm_mon_chk.sv
module e1_rx_alarm_mon_chk (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic rx_bit,
    input logic nfas_b3_stb,
    input logic ts16_b6_stb,
    input logic sa7_stb,
    input logic win_end,
    input logic frame_sync,
    input logic resync_req,
    input logic los_o,
    input logic carrier_loss_o,
    input logic remote_alarm_o,
    input logic all_ones_o,
    input logic dist_mf_alarm_o,
    input logic link_alarm_o
);
    a_r1_sync_rise_clears: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_sync) && !resync_req) |=> !los_o);

    a_r2_resync_sets: assert property (@(posedge clk) disable iff (rst)
        resync_req |=> los_o);

    a_r2_sync_fall_sets: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_sync) |=> los_o);

    a_r3_set_on_valid_zero: assert property (@(posedge clk) disable iff (rst)
        (!carrier_loss_o && !(bit_vld && !rx_bit)) |=> !carrier_loss_o);

    a_r4_clear_on_valid_bit: assert property (@(posedge clk) disable iff (rst)
        (carrier_loss_o && !bit_vld) |=> carrier_loss_o);

    a_r5_ra_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bit_vld && nfas_b3_stb) |=> $stable(remote_alarm_o));

    a_r6_ao_moves_on_marker: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(all_ones_o));

    a_r7_dma_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bit_vld && ts16_b6_stb) |=> $stable(dist_mf_alarm_o));

    a_r8_link_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bit_vld && sa7_stb) |=> $stable(link_alarm_o));

    a_r5_ra_rise_needs_one: assert property (@(posedge clk) disable iff (rst)
        $rose(remote_alarm_o) |-> $past(rx_bit));
endmodule

bind e1_rx_alarm_mon e1_rx_alarm_mon_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .bit_vld         (bit_vld),
    .rx_bit          (rx_bit),
    .nfas_b3_stb     (nfas_b3_stb),
    .ts16_b6_stb     (ts16_b6_stb),
    .sa7_stb         (sa7_stb),
    .win_end         (win_end),
    .frame_sync      (frame_sync),
    .resync_req      (resync_req),
    .los_o           (los_o),
    .carrier_loss_o  (carrier_loss_o),
    .remote_alarm_o  (remote_alarm_o),
    .all_ones_o      (all_ones_o),
    .dist_mf_alarm_o (dist_mf_alarm_o),
    .link_alarm_o    (link_alarm_o)
);

// File: tb/e1_rx_alarm_mon_bench.sv
`timescale 1ns/1ps
module e1_rx_alarm_mon_bench;

    localparam logic [5:0] M_LOS = 6'b100000;
    localparam logic [5:0] M_CL  = 6'b010000;
    localparam logic [5:0] M_RA  = 6'b001000;
    localparam logic [5:0] M_AO  = 6'b000100;
    localparam logic [5:0] M_DMA = 6'b000010;
    localparam logic [5:0] M_LNK = 6'b000001;

    typedef struct {
        string      tag;
        logic [5:0] exp;
        logic [5:0] msk;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0, rx_bit = 1'b0;
    logic nfas_b3_stb = 1'b0, ts16_b6_stb = 1'b0, sa7_stb = 1'b0, win_end = 1'b0;
    logic frame_sync = 1'b0, resync_req = 1'b0, cl_long_sel = 1'b0;
    logic los_o, carrier_loss_o, remote_alarm_o, all_ones_o, dist_mf_alarm_o, link_alarm_o;

    exp_item_t sb_q[$];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;

    always #10 clk = ~clk;

    e1_rx_alarm_mon u_e1_rx_alarm_mon (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .nfas_b3_stb(nfas_b3_stb), .ts16_b6_stb(ts16_b6_stb), .sa7_stb(sa7_stb),
        .win_end(win_end), .frame_sync(frame_sync), .resync_req(resync_req),
        .cl_long_sel(cl_long_sel), .los_o(los_o), .carrier_loss_o(carrier_loss_o),
        .remote_alarm_o(remote_alarm_o), .all_ones_o(all_ones_o),
        .dist_mf_alarm_o(dist_mf_alarm_o), .link_alarm_o(link_alarm_o)
    );

    task automatic expect_out(input string tag, input logic [5:0] e, input logic [5:0] m);
        exp_item_t it;
        it.tag = tag; it.exp = e; it.msk = m;
        sb_q.push_back(it);
    endtask

    // drive one cycle: bit, valid, strobes (nfas, ts16, sa7, window end)
    task automatic drv(input logic b, input logic v, input logic nf,
                       input logic t16, input logic sa, input logic mk);
        @(negedge clk);
        rx_bit = b; bit_vld = v; nfas_b3_stb = nf;
        ts16_b6_stb = t16; sa7_stb = sa; win_end = mk;
    endtask

    task automatic bits(input logic b, input int n);
        for (int i = 0; i < n; i++) drv(b, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // monitor: compares every queued item after the edge that consumed its inputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {los_o, carrier_loss_o, remote_alarm_o, all_ones_o,
                       dist_mf_alarm_o, link_alarm_o};
                n_chk++;
                if ((act & it.msk) !== (it.exp & it.msk)) begin
                    n_bad++;
                    $display("FAIL %s actual=%b expected=%b mask=%b",
                             it.tag, act & it.msk, it.exp & it.msk, it.msk);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R10 reset values", 6'b100000, 6'b111111);
        @(negedge clk); rst = 1'b0;
        expect_out("R1 los held before sync", M_LOS, M_LOS);

        // R1 / R2 loss-of-sync
        @(negedge clk); frame_sync = 1'b1;
        expect_out("R1 los clears on sync rise", 6'b0, M_LOS);
        @(negedge clk); frame_sync = 1'b0;
        expect_out("R2 los sets on sync fall", M_LOS, M_LOS);
        @(negedge clk); frame_sync = 1'b1;
        expect_out("R1 los clears again", 6'b0, M_LOS);
        @(negedge clk); resync_req = 1'b1;
        expect_out("R2 los sets on manual resync", M_LOS, M_LOS);
        @(negedge clk); resync_req = 1'b0;
        expect_out("R2 los stays set until next rise", M_LOS, M_LOS);

        // R3 carrier loss, short threshold (first valid bit starts window 1)
        bits(1'b0, 254);
        expect_out("R3 no loss at 254 zeros", 6'b0, M_CL);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R3 invalid zeros not counted", 6'b0, M_CL);
        bits(1'b0, 1);
        expect_out("R3 loss at 255 zeros", M_CL, M_CL);

        // R4 window 2: 31 ones keeps the alarm
        bits(1'b1, 31);
        bits(1'b0, 224);
        expect_out("R4 31 ones keep loss", M_CL, M_CL);
        // window 3: 32 ones clears at the window end
        bits(1'b1, 32);
        bits(1'b0, 222);
        expect_out("R4 loss held inside window", M_CL, M_CL);
        bits(1'b0, 1);
        expect_out("R4 loss clears at window end", 6'b0, M_CL);

        // R3 long threshold
        cl_long_sel = 1'b1;
        bits(1'b1, 1);
        bits(1'b0, 2047);
        expect_out("R3 no loss at 2047 zeros", 6'b0, M_CL);
        bits(1'b0, 1);
        expect_out("R3 loss at 2048 zeros", M_CL, M_CL);

        // R5 remote alarm
        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R5 two ones not enough", 6'b0, M_RA);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R5 set after three ones", M_RA, M_RA);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R9 unqualified nfas strobes ignored", M_RA, M_RA);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R5 broken zero run keeps alarm", M_RA, M_RA);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R5 two zeros not enough", M_RA, M_RA);
        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_out("R5 clear after three zeros", 6'b0, M_RA);

        // R7 distant multiframe alarm
        drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R7 one sample not enough", 6'b0, M_DMA);
        drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R7 set after two ones", M_DMA, M_DMA);
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R9 unqualified ts16 strobes ignored", M_DMA, M_DMA);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R7 broken zero run keeps alarm", M_DMA, M_DMA);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R7 clear after two zeros", 6'b0, M_DMA);

        // R6 all-ones windows
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 flush window with many zeros", 6'b0, M_AO);
        bits(1'b1, 1); bits(1'b0, 1); bits(1'b1, 2); bits(1'b0, 1);
        expect_out("R6 no change before marker", 6'b0, M_AO);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 two zeros sets all-ones", M_AO, M_AO);
        bits(1'b0, 1); bits(1'b1, 2);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 two zeros incl marker bit keeps set", M_AO, M_AO);
        bits(1'b0, 2); bits(1'b1, 1);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 three zeros clears", 6'b0, M_AO);
        bits(1'b1, 3);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 no zeros sets again", M_AO, M_AO);

        // R8 Sa7 vote
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 one zero of three", 6'b0, M_LNK);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R9 unqualified sa7 strobe ignored", 6'b0, M_LNK);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 two zeros asserts", M_LNK, M_LNK);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 zero zero one still asserts", M_LNK, M_LNK);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 zero one one clears", 6'b0, M_LNK);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 one zero one stays clear", 6'b0, M_LNK);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 zero one zero asserts", M_LNK, M_LNK);

        drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #2;
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule